// File: doc/BRIEF.md
# Scratchpad Address Router

This block sits between a processor's single memory access port and two small on-chip scratchpad memories: one meant for instructions and one for data. Each request carries an address, an access size, a direction, a fetch flag and a sequential-beat flag. The router aligns the address to the access size and decodes it against the two programmable windows. A hit on a scratchpad is served from the internal scratchpad storage and costs one cycle. A miss becomes a request on an external bus port. That bus request holds until the bus acknowledges, and the bus also supplies the cycle cost of the region that was reached.

The instruction window always starts at address zero. Its size comes from a 5-bit exponent in its configuration word. The data window can be relocated: its base is the upper 20 bits of its configuration word, and its size uses the same exponent encoding. Each window is enabled by its own bit of a control word. When a window is larger than the physical storage behind it, the storage repeats through the window. A running cycle count lets a burst total its beats.

The controller has four states:
- `S_IDLE` accepts a request. It moves to `S_TCM` on a scratchpad hit and to `S_BUS` on a miss.
- `S_TCM` performs the scratchpad read or write and moves to `S_DONE`.
- `S_BUS` holds the bus request and moves to `S_DONE` on acknowledge.
- `S_DONE` presents the result for one cycle and returns to `S_IDLE`.

Top module: `tcm_router`

## Requirements
- R1: After reset the block is in `S_IDLE`. In that state `acc_ready` is 1, `acc_done` is 0, `bus_req` is 0 and `acc_cycles` is 0.
- R2: The instruction window is enabled by `ctl_word` bit 18. It covers addresses from 0 up to, but not including, 0x200 shifted left by `itcm_cfg[5:1]`. A hit there sets `acc_cycles` to 1 and raises no bus request. With bit 18 clear, the same address goes to the bus.
- R3: The data window is enabled by `ctl_word` bit 16. Its base is `dtcm_cfg` with bits [11:0] cleared, and its size is 0x200 shifted left by `dtcm_cfg[5:1]`. An address below the base, or at or above base plus size, goes to the bus. When bit 16 is clear, no address matches the data window.
- R4: Addresses are tested against the instruction window first, then the data window, then the bus. A fetch (`acc_fetch`=1) tests only the instruction window. A fetch is always a read, so `acc_wr` is ignored during a fetch.
- R5: Before decoding, a halfword access (size code 1) clears address bit 0 and a word access (size code 2) clears bits [1:0]. The bus address carries the same alignment. A byte access uses size code 0.
- R6: A byte write changes only byte lane `addr[1:0]` of the 32-bit word. A halfword write changes only lanes 1:0 or 3:2, as selected by `addr[1]`. Byte and halfword reads return the addressed lanes zero-extended into the low bits of `acc_rdata`.
- R7: The scratchpad offset is taken modulo the physical size, so a window larger than the storage repeats the storage.
- R8: On a miss, `bus_req` stays high until `bus_ack`. While it is high, `bus_addr`, `bus_size`, `bus_wr` and `bus_wdata` hold the aligned request and do not change. The result takes `acc_rdata` from `bus_rdata` and `acc_cycles` from `bus_lat`, both sampled at the acknowledge.
- R9: When `acc_seq`=1, the cost of the access is added to `acc_cycles`. When `acc_seq`=0, the cost replaces it.
- R10: `acc_done` is a one-cycle pulse. A scratchpad hit raises it two clock edges after acceptance. `acc_ready` is low from the cycle after acceptance until the block returns to `S_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_word | input | 32 | Control word; bit 16 enables the data window, bit 18 enables the instruction window |
| itcm_cfg | input | 32 | Instruction window setting; bits [5:1] hold the size exponent |
| dtcm_cfg | input | 32 | Data window setting; bits [31:12] hold the base and bits [5:1] the size exponent |
| acc_req | input | 1 | Access request, accepted when `acc_ready` is high |
| acc_ready | output | 1 | Block is idle and can accept a request |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_wr | input | 1 | Access is a write |
| acc_seq | input | 1 | Access is a sequential beat; its cost accumulates |
| acc_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| acc_addr | input | 32 | Byte address |
| acc_wdata | input | 32 | Write data, right-justified |
| acc_done | output | 1 | One-cycle completion pulse |
| acc_rdata | output | 32 | Read data, zero-extended |
| acc_cycles | output | 8 | Running cycle count |
| bus_req | output | 1 | External bus request |
| bus_wr | output | 1 | External bus write |
| bus_size | output | 2 | External bus access size |
| bus_addr | output | 32 | External bus aligned address |
| bus_wdata | output | 32 | External bus write data |
| bus_ack | input | 1 | External bus acknowledge |
| bus_rdata | input | 32 | External bus read data |
| bus_lat | input | 8 | Cycle cost of the region reached, valid with `bus_ack` |

## Verification
The hardest case to reach from the ports is the one where both windows are enabled and overlap, so that the instruction window's priority decides the target. Writing the same address through one window shows nothing on its own. The stimulus therefore works in steps:
1. With the instruction window off, a write fills the data scratchpad.
2. With both windows on, a second write to the same address must land in the instruction scratchpad.
3. Turning the instruction window back off exposes the untouched data word.

Repetition is reached the same way. A value is written inside the physical storage and read back through an address one storage size higher. The sequential-beat sum is reached by chaining a scratchpad beat and a bus beat after a bus access.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_TCM  = 2'd1,
        S_BUS  = 2'd2,
        S_DONE = 2'd3
    } rt_state_t;

    typedef enum logic [1:0] {
        T_INSN = 2'd0,
        T_DATA = 2'd1,
        T_BUS  = 2'd2
    } rt_target_t;
endpackage

// File: rtl/tcm_window.sv
module tcm_window #(
    parameter int  WORDS  = 64,
    parameter bit  PINNED = 1'b0,
    localparam int IW     = $clog2(WORDS)
) (
    input  logic          en,
    input  logic          allow,
    input  logic [31:0]   cfg,
    input  logic [31:0]   addr,
    output logic          hit,
    output logic [IW-1:0] idx
);
    logic [63:0] base;
    logic [63:0] span;
    logic [63:0] a64;
    logic [63:0] off;

    always_comb begin
        if (en) begin
            base = PINNED ? 64'd0 : {32'd0, cfg[31:12], 12'd0};
            span = 64'h200 << cfg[5:1];
        end else begin
            base = 64'h0000_0000_FFFF_FFFF;
            span = 64'd0;
        end
        a64 = {32'd0, addr};
        hit = allow && (a64 >= base) && (a64 < (base + span));
        off = a64 - base;
        idx = off[IW+1:2];
    end
endmodule

// File: rtl/tcm_bank.sv
module tcm_bank #(
    parameter int  WORDS = 64,
    localparam int IW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [3:0]    be,
    input  logic [IW-1:0] idx,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);
    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [7:0] lane_mem [WORDS];
        always_ff @(posedge clk) begin
            if (we && be[g]) begin
                lane_mem[idx] <= wdata[8*g +: 8];
            end
        end
        assign rdata[8*g +: 8] = lane_mem[idx];
    end
endmodule

// File: rtl/tcm_router.sv
module tcm_router
    import tcm_pkg::*;
#(
    parameter int  ITCM_WORDS = 64,
    parameter int  DTCM_WORDS = 64,
    parameter int  CW         = 8,
    localparam int IIW        = $clog2(ITCM_WORDS),
    localparam int DIW        = $clog2(DTCM_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [31:0]   ctl_word,
    input  logic [31:0]   itcm_cfg,
    input  logic [31:0]   dtcm_cfg,
    input  logic          acc_req,
    output logic          acc_ready,
    input  logic          acc_fetch,
    input  logic          acc_wr,
    input  logic          acc_seq,
    input  logic [1:0]    acc_size,
    input  logic [31:0]   acc_addr,
    input  logic [31:0]   acc_wdata,
    output logic          acc_done,
    output logic [31:0]   acc_rdata,
    output logic [CW-1:0] acc_cycles,
    output logic          bus_req,
    output logic          bus_wr,
    output logic [1:0]    bus_size,
    output logic [31:0]   bus_addr,
    output logic [31:0]   bus_wdata,
    input  logic          bus_ack,
    input  logic [31:0]   bus_rdata,
    input  logic [CW-1:0] bus_lat
);
    rt_state_t  st, st_nx;
    rt_target_t tgt_q;
    logic [31:0]    a_al, a_q, wd_q, rdata_q;
    logic [1:0]     size_q;
    logic           wr_q, seq_q;
    logic [IIW-1:0] i_idx, i_idx_q;
    logic [DIW-1:0] d_idx, d_idx_q;
    logic           i_hit, d_hit;
    logic [CW-1:0]  cyc_q;
    logic [3:0]     lanes;
    logic [31:0]    wd_rep, i_rd, d_rd, word_rd, ext_rd;
    logic           i_we, d_we;

    // Size alignment before decode
    always_comb begin
        unique case (acc_size)
            SZ_HALF: a_al = {acc_addr[31:1], 1'b0};
            SZ_WORD: a_al = {acc_addr[31:2], 2'b00};
            default: a_al = acc_addr;
        endcase
    end

    tcm_window #(.WORDS(ITCM_WORDS), .PINNED(1'b1)) u_iwin (
        .en(ctl_word[18]), .allow(1'b1), .cfg(itcm_cfg),
        .addr(a_al), .hit(i_hit), .idx(i_idx)
    );

    tcm_window #(.WORDS(DTCM_WORDS), .PINNED(1'b0)) u_dwin (
        .en(ctl_word[16]), .allow(!acc_fetch), .cfg(dtcm_cfg),
        .addr(a_al), .hit(d_hit), .idx(d_idx)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // Next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: if (acc_req) st_nx = (i_hit || d_hit) ? S_TCM : S_BUS;
            S_TCM:  st_nx = S_DONE;
            S_BUS:  if (bus_ack) st_nx = S_DONE;
            S_DONE: st_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        acc_ready = (st == S_IDLE);
        acc_done  = (st == S_DONE);
        bus_req   = (st == S_BUS);
    end
    assign acc_rdata  = rdata_q;
    assign acc_cycles = cyc_q;
    assign bus_wr     = wr_q;
    assign bus_size   = size_q;
    assign bus_addr   = a_q;
    assign bus_wdata  = wd_q;

    // Lane enables and write replication from captured request
    always_comb begin
        unique case (size_q)
            SZ_BYTE: begin lanes = 4'b0001 << a_q[1:0];         wd_rep = {4{wd_q[7:0]}};  end
            SZ_HALF: begin lanes = a_q[1] ? 4'b1100 : 4'b0011;  wd_rep = {2{wd_q[15:0]}}; end
            default: begin lanes = 4'b1111;                      wd_rep = wd_q;            end
        endcase
    end

    assign i_we = (st == S_TCM) && (tgt_q == T_INSN) && wr_q;
    assign d_we = (st == S_TCM) && (tgt_q == T_DATA) && wr_q;

    tcm_bank #(.WORDS(ITCM_WORDS)) u_ibank (
        .clk(clk), .we(i_we), .be(lanes), .idx(i_idx_q), .wdata(wd_rep), .rdata(i_rd)
    );

    tcm_bank #(.WORDS(DTCM_WORDS)) u_dbank (
        .clk(clk), .we(d_we), .be(lanes), .idx(d_idx_q), .wdata(wd_rep), .rdata(d_rd)
    );

    // Read lane extraction
    always_comb begin
        word_rd = (tgt_q == T_INSN) ? i_rd : d_rd;
        unique case (size_q)
            SZ_BYTE: ext_rd = {24'd0, word_rd[8*a_q[1:0] +: 8]};
            SZ_HALF: ext_rd = {16'd0, word_rd[16*a_q[1] +: 16]};
            default: ext_rd = word_rd;
        endcase
    end

    // Datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q   <= T_BUS;
            a_q     <= '0;
            wd_q    <= '0;
            size_q  <= SZ_BYTE;
            wr_q    <= 1'b0;
            seq_q   <= 1'b0;
            i_idx_q <= '0;
            d_idx_q <= '0;
            rdata_q <= '0;
            cyc_q   <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (acc_req) begin
                    tgt_q   <= i_hit ? T_INSN : (d_hit ? T_DATA : T_BUS);
                    a_q     <= a_al;
                    wd_q    <= acc_wdata;
                    size_q  <= acc_size;
                    wr_q    <= acc_wr && !acc_fetch;
                    seq_q   <= acc_seq;
                    i_idx_q <= i_idx;
                    d_idx_q <= d_idx;
                end
                S_TCM: begin
                    rdata_q <= ext_rd;
                    cyc_q   <= seq_q ? cyc_q + CW'(1) : CW'(1);
                end
                S_BUS: if (bus_ack) begin
                    rdata_q <= bus_rdata;
                    cyc_q   <= seq_q ? cyc_q + bus_lat : bus_lat;
                end
                default: ;
            endcase
        end
    end

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_size))); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> !acc_done); // R10
    AST_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_ready) |=> !acc_ready); // R10
    AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_ready && (i_hit || d_hit)) |=> (!bus_req ##1 acc_done)); // R2
    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_size == 2'd2) |-> (bus_addr[1:0] == 2'b00)); // R5
    AST_HALF_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_size == 2'd1) |-> !bus_addr[0]); // R5
endmodule

// File: tb/tcm_router_bench.sv
module tcm_router_bench;
    typedef struct packed {
        logic [31:0] ctl;
        logic        fetch;
        logic        wr;
        logic        seq;
        logic [1:0]  size;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic        xbus;
        logic [31:0] xdata;
        logic [7:0]  xcyc;
    } vec_t;

    localparam logic [31:0] CB = 32'h0005_0000;
    localparam logic [31:0] CI = 32'h0004_0000;
    localparam logic [31:0] CD = 32'h0001_0000;
    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{CB,1'b0,1'b1,1'b0,2'd2,32'h0000_0010,32'h1122_3344,1'b0,32'h0,8'd1},        // R2
        '{CB,1'b0,1'b0,1'b0,2'd2,32'h0000_0110,32'h0,1'b0,32'h1122_3344,8'd1},        // R7
        '{CB,1'b0,1'b1,1'b0,2'd2,32'h0000_0020,32'hCAFE_F00D,1'b0,32'h0,8'd1},
        '{CB,1'b0,1'b1,1'b0,2'd0,32'h0000_0021,32'h0000_0077,1'b0,32'h0,8'd1},        // R6
        '{CB,1'b0,1'b0,1'b0,2'd2,32'h0000_0020,32'h0,1'b0,32'hCAFE_770D,8'd1},        // R6
        '{CB,1'b0,1'b0,1'b0,2'd0,32'h0000_0022,32'h0,1'b0,32'h0000_00FE,8'd1},        // R6
        '{CB,1'b0,1'b0,1'b0,2'd1,32'h0000_0023,32'h0,1'b0,32'h0000_CAFE,8'd1},        // R5
        '{CB,1'b0,1'b1,1'b0,2'd2,32'h0000_0030,32'h0,1'b0,32'h0,8'd1},
        '{CB,1'b0,1'b1,1'b0,2'd1,32'h0000_0032,32'h0000_1234,1'b0,32'h0,8'd1},        // R6
        '{CB,1'b0,1'b0,1'b0,2'd2,32'h0000_0030,32'h0,1'b0,32'h1234_0000,8'd1},        // R6
        '{CB,1'b0,1'b1,1'b0,2'd2,32'h0200_0040,32'hDEAD_BEEF,1'b0,32'h0,8'd1},        // R3
        '{CB,1'b0,1'b0,1'b0,2'd2,32'h0200_0140,32'h0,1'b0,32'hDEAD_BEEF,8'd1},        // R7
        '{CB,1'b1,1'b0,1'b0,2'd2,32'h0200_0040,32'h0,1'b1,32'h585A_0040,8'd4},        // R4
        '{CB,1'b0,1'b0,1'b0,2'd2,32'h0000_0400,32'h0,1'b1,32'h5A5A_0400,8'd2},        // R2
        '{CB,1'b0,1'b1,1'b0,2'd2,32'h0000_03FC,32'h0BAD_CAFE,1'b0,32'h0,8'd1},        // R2
        '{CB,1'b0,1'b0,1'b0,2'd2,32'h0000_00FC,32'h0,1'b0,32'h0BAD_CAFE,8'd1},        // R7
        '{CB,1'b0,1'b0,1'b0,2'd2,32'h0200_1000,32'h0,1'b1,32'h585A_1000,8'd4},        // R3
        '{CB,1'b0,1'b0,1'b1,2'd2,32'h0000_0010,32'h0,1'b0,32'h1122_3344,8'd5},        // R9
        '{CB,1'b0,1'b0,1'b1,2'd2,32'h0000_0400,32'h0,1'b1,32'h5A5A_0400,8'd7},        // R9
        '{CB,1'b0,1'b0,1'b0,2'd2,32'h01FF_FFFC,32'h0,1'b1,32'h5BA5_FFFC,8'd3},        // R3
        '{CD,1'b0,1'b0,1'b0,2'd2,32'h0000_0010,32'h0,1'b1,32'h5A5A_0010,8'd2},        // R2
        '{CI,1'b0,1'b0,1'b0,2'd2,32'h0200_0040,32'h0,1'b1,32'h585A_0040,8'd4},        // R3
        '{CB,1'b1,1'b1,1'b0,2'd2,32'h0000_0010,32'hFFFF_FFFF,1'b0,32'h0,8'd1},        // R4
        '{CB,1'b0,1'b0,1'b0,2'd2,32'h0000_0010,32'h0,1'b0,32'h1122_3344,8'd1},        // R4
        '{CB,1'b0,1'b0,1'b0,2'd0,32'h0200_0043,32'h0,1'b0,32'h0000_00DE,8'd1}         // R6
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] ctl_word = '0, itcm_cfg = 32'h2, dtcm_cfg = 32'h0200_0006;
    logic acc_req = 1'b0, acc_fetch = 1'b0, acc_wr = 1'b0, acc_seq = 1'b0;
    logic [1:0] acc_size = 2'd0;
    logic [31:0] acc_addr = '0, acc_wdata = '0;
    logic acc_ready, acc_done, bus_req, bus_wr;
    logic [31:0] acc_rdata, bus_addr, bus_wdata;
    logic [7:0] acc_cycles;
    logic [1:0] bus_size;
    logic bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic [7:0] bus_lat = '0;

    int n_chk = 0, n_bad = 0;
    logic bus_seen;
    logic [31:0] log_addr, log_wdata;
    logic [1:0] log_size;
    logic log_wr;
    int bwait = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tcm_router u_tcm_router (
        .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word), .itcm_cfg(itcm_cfg), .dtcm_cfg(dtcm_cfg),
        .acc_req(acc_req), .acc_ready(acc_ready), .acc_fetch(acc_fetch), .acc_wr(acc_wr),
        .acc_seq(acc_seq), .acc_size(acc_size), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_done(acc_done), .acc_rdata(acc_rdata), .acc_cycles(acc_cycles),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_size(bus_size), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_lat(bus_lat)
    );

    // Bus model: acknowledge two cycles after the request; cost from address bits [27:24]
    always @(negedge clk) begin
        if (bus_req && !bus_ack) begin
            bus_seen  <= 1'b1;
            log_addr  <= bus_addr;
            log_wdata <= bus_wdata;
            log_size  <= bus_size;
            log_wr    <= bus_wr;
            if (bwait == 1) begin
                bus_ack   <= 1'b1;
                bus_rdata <= bus_addr ^ 32'h5A5A_0000;
                bus_lat   <= {4'd0, bus_addr[27:24]} + 8'd2;
            end
            bwait <= bwait + 1;
        end else begin
            bus_ack <= 1'b0;
            bwait   <= 0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic f, input logic w, input logic s, input logic [1:0] sz,
                          input logic [31:0] a, input logic [31:0] wd);
        int t;
        t = 0;
        while (!acc_ready && t < 50) begin @(negedge clk); t++; end
        bus_seen  = 1'b0;
        acc_fetch = f; acc_wr = w; acc_seq = s; acc_size = sz; acc_addr = a; acc_wdata = wd;
        acc_req   = 1'b1;
        @(negedge clk);
        acc_req = 1'b0;
        t = 0;
        while (!acc_done && t < 50) begin @(negedge clk); t++; end
        if (!acc_done) check("R10 done timeout", 32'd0, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ready", {31'd0, acc_ready}, 32'd1);
        check("R1 done", {31'd0, acc_done}, 32'd0);
        check("R1 bus_req", {31'd0, bus_req}, 32'd0);
        check("R1 cycles", {24'd0, acc_cycles}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            ctl_word = VECS[i].ctl;
            access(VECS[i].fetch, VECS[i].wr, VECS[i].seq, VECS[i].size, VECS[i].addr, VECS[i].wdata);
            check($sformatf("vec%0d bus use", i), {31'd0, bus_seen}, {31'd0, VECS[i].xbus});
            check($sformatf("vec%0d cycles", i), {24'd0, acc_cycles}, {24'd0, VECS[i].xcyc});
            if (!VECS[i].wr)
                check($sformatf("vec%0d rdata", i), acc_rdata, VECS[i].xdata);
        end

        // R10 done is a single pulse
        @(negedge clk);
        check("R10 done pulse", {31'd0, acc_done}, 32'd0);

        // R8 R5 bus write carries aligned request
        ctl_word = CB;
        access(1'b0, 1'b1, 1'b0, 2'd2, 32'h0000_0403, 32'hA1B2_C3D4);
        check("R8 bus write addr", log_addr, 32'h0000_0400);
        check("R8 bus wdata", log_wdata, 32'hA1B2_C3D4);
        check("R8 bus wr", {31'd0, log_wr}, 32'd1);
        access(1'b0, 1'b1, 1'b0, 2'd1, 32'h0000_0403, 32'h0000_BEEF);
        check("R5 half bus addr", log_addr, 32'h0000_0402);
        check("R5 half bus size", {30'd0, log_size}, 32'd1);

        // R4 priority with overlapping windows (data base at zero)
        dtcm_cfg = 32'h0000_0006;
        ctl_word = CD;
        access(1'b0, 1'b1, 1'b0, 2'd2, 32'h0000_0044, 32'h0000_D0D0);
        check("R4 data write no bus", {31'd0, bus_seen}, 32'd0);
        ctl_word = CB;
        access(1'b0, 1'b1, 1'b0, 2'd2, 32'h0000_0044, 32'h0000_1717);
        access(1'b0, 1'b0, 1'b0, 2'd2, 32'h0000_0044, 32'h0);
        check("R4 insn window wins", acc_rdata, 32'h0000_1717);
        ctl_word = CD;
        access(1'b0, 1'b0, 1'b0, 2'd2, 32'h0000_0044, 32'h0);
        check("R4 data word untouched", acc_rdata, 32'h0000_D0D0);

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual expired expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule